// File: doc/BRIEF.md
# Spread-Spectrum Fractional Divider Modulator

This block produces, once per reference clock, the feedback divider word of a fractional-N frequency synthesizer. The word has an integer part and a binary fraction. With modulation off, the word is the programmed nominal value. With modulation on, a triangular deviation is subtracted from the nominal word. This spreads the synthesized frequency either wholly below nominal (down-spread) or evenly around it (center-spread).

The triangle is set by three 16-bit parameters: a half-period count H, a step size S and an adjustment interval A. The deviation changes by S once every A+1 reference cycles. It falls for H+1 such steps and then rises for H+1 steps, so one triangle lasts 2·(H+1)·(A+1) reference cycles and its peak is S·(H+1). Software loads every parameter as byte-wide fields through a simple write port, and the block assembles them. Writes go to a shadow copy. That copy becomes active only at the start of a triangle, or on the next cycle while modulation is off. A change made mid-sweep therefore never bends the current triangle.

Top module: `ssc_fracdiv_mod`

## Requirements
- R1: After reset the output word is zero, the shadow and active settings are zero, and modulation is off.
- R2: The nominal word is {integer, fraction}, 8 + 18 bits. The integer byte is written at address 0. The fraction is written at addresses 1 (bits 7:0), 2 (bits 15:8) and 3 (bits 1:0 of the data give fraction bits 17:16; data bits 7:2 are dropped).
- R3: While the active enable is clear, the output equals the active nominal word, the phase counters are zero, and a shadow write is visible at the output two clock edges after the edge that captured it.
- R4: At the control address 4, data bit 1 enables modulation and data bit 0 selects center-spread (1) or down-spread (0). All other data bits are ignored, and bit 0 alone does not start modulation.
- R5: In down-spread mode the output is the nominal word minus the deviation. The deviation is t·S for t ≤ H+1 and (2(H+1) − t)·S after that, where t is the number of steps taken since the triangle started. The first reference cycle of a triangle outputs the nominal word.
- R6: In center-spread mode the output is nominal + floor(peak/2) − deviation, where peak = S·(H+1).
- R7: A step happens only on the reference cycles whose index since the triangle start is a nonzero multiple of A+1. The index is counted in cycles after the edge that loaded the active settings.
- R8: A triangle lasts exactly 2·(H+1)·(A+1) reference cycles, after which the deviation is zero again.
- R9: H (addresses 5 low, 6 high), S (7, 8), A (9, 10), the nominal word and the control bits are double-buffered. A write made while modulation runs takes effect only at the next triangle start, and clearing the enable likewise stops modulation only at the end of the current triangle.
- R10: The deviation saturates at 2^26−1 instead of wrapping, never goes below zero, and the peak used for centering saturates the same way. The output word clamps to the range 0 … 2^26−1.
- R11: Writes to addresses 11 to 15 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one output word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Byte write strobe for the settings |
| cfg_addr | input | 4 | Setting address |
| cfg_wdata | input | 8 | Byte written |
| div_word | output | 26 | Instantaneous divider word, integer part in the top 8 bits |

## Verification
The embedded properties watch invariants on every cycle. The phase counters stay at zero while idle and inside their programmed bounds while sweeping. The deviation only grows on falling steps and only shrinks on rising steps. The down-spread word never rises above nominal, and the active settings move only on a load. The exact arithmetic cannot be shown by those properties and is left to the bench's scenarios: the word at every cycle of a triangle, the step timing against A, the center offset, the point where a mid-sweep write takes effect, and the values reached under saturation and clamping. The bench sweeps small H, A and S values in both modes and compares each cycle with a closed-form model.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // Direction of the deviation ramp within one triangle.
    typedef enum logic {
        RAMP_FALL = 1'b0,   // deviation growing, word moving away from nominal
        RAMP_RISE = 1'b1    // deviation shrinking, word returning to nominal
    } ramp_dir_e;

    localparam int BYTE_W          = 8;
    localparam int CTRL_CENTER_BIT = 0;
    localparam int CTRL_ENABLE_BIT = 1;

    function automatic int bytes_for(input int width);
        return (width + BYTE_W - 1) / BYTE_W;
    endfunction

endpackage

// File: rtl/ssc_cfg_bank.sv
module ssc_cfg_bank
    import ssc_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 18,
    parameter int PRM_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic                      load_i,
    output logic                      act_en_o,
    output logic                      act_center_o,
    output logic [INT_W+FRAC_W-1:0]   act_nom_o,
    output logic [PRM_W-1:0]          act_half_o,
    output logic [PRM_W-1:0]          act_step_o,
    output logic [PRM_W-1:0]          act_adj_o,
    output logic [INT_W+FRAC_W-1:0]   act_peak_o
);

    localparam int WORD_W     = INT_W + FRAC_W;
    localparam int INT_BYTES  = bytes_for(INT_W);
    localparam int FRAC_BYTES = bytes_for(FRAC_W);
    localparam int PRM_BYTES  = bytes_for(PRM_W);
    localparam int A_INT      = 0;
    localparam int A_FRAC     = A_INT + INT_BYTES;
    localparam int A_CTRL     = A_FRAC + FRAC_BYTES;
    localparam int A_HALF     = A_CTRL + 1;
    localparam int A_STEP     = A_HALF + PRM_BYTES;
    localparam int A_ADJ      = A_STEP + PRM_BYTES;
    localparam int PROD_RAW   = 2 * PRM_W + 1;
    localparam int PROD_W     = (PROD_RAW > WORD_W + 1) ? PROD_RAW : WORD_W + 1;
    localparam logic [PROD_W-1:0] PEAK_CAP = PROD_W'({WORD_W{1'b1}});

    typedef struct packed {
        logic [INT_W-1:0]  nom_int;
        logic [FRAC_W-1:0] nom_frac;
        logic              center;
        logic              en;
        logic [PRM_W-1:0]  half;
        logic [PRM_W-1:0]  step;
        logic [PRM_W-1:0]  adj;
    } cfg_t;

    typedef struct packed {
        cfg_t              shd;
        cfg_t              act;
        logic [WORD_W-1:0] peak;
    } bank_t;

    bank_t             q, d;
    logic [PROD_W-1:0] prod;

    always_comb begin
        d = q;

        // Shadow byte writes, assembled little-endian within each field.
        for (int k = 0; k < INT_BYTES; k++)
            if (wr_en && wr_addr == ADDR_W'(A_INT + k))
                for (int b = 0; b < BYTE_W; b++)
                    if (k * BYTE_W + b < INT_W) d.shd.nom_int[k * BYTE_W + b] = wr_data[b];

        for (int k = 0; k < FRAC_BYTES; k++)
            if (wr_en && wr_addr == ADDR_W'(A_FRAC + k))
                for (int b = 0; b < BYTE_W; b++)
                    if (k * BYTE_W + b < FRAC_W) d.shd.nom_frac[k * BYTE_W + b] = wr_data[b];

        if (wr_en && wr_addr == ADDR_W'(A_CTRL)) begin
            d.shd.center = wr_data[CTRL_CENTER_BIT];
            d.shd.en     = wr_data[CTRL_ENABLE_BIT];
        end

        for (int k = 0; k < PRM_BYTES; k++) begin
            if (wr_en && wr_addr == ADDR_W'(A_HALF + k))
                for (int b = 0; b < BYTE_W; b++)
                    if (k * BYTE_W + b < PRM_W) d.shd.half[k * BYTE_W + b] = wr_data[b];
            if (wr_en && wr_addr == ADDR_W'(A_STEP + k))
                for (int b = 0; b < BYTE_W; b++)
                    if (k * BYTE_W + b < PRM_W) d.shd.step[k * BYTE_W + b] = wr_data[b];
            if (wr_en && wr_addr == ADDR_W'(A_ADJ + k))
                for (int b = 0; b < BYTE_W; b++)
                    if (k * BYTE_W + b < PRM_W) d.shd.adj[k * BYTE_W + b] = wr_data[b];
        end

        // Peak deviation of the pending settings, saturated to the word range.
        prod = PROD_W'(q.shd.step) * (PROD_W'(q.shd.half) + PROD_W'(1));

        if (load_i) begin
            d.act  = q.shd;
            d.peak = (prod > PEAK_CAP) ? {WORD_W{1'b1}} : prod[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_en_o     = q.act.en;
    assign act_center_o = q.act.center;
    assign act_nom_o    = {q.act.nom_int, q.act.nom_frac};
    assign act_half_o   = q.act.half;
    assign act_step_o   = q.act.step;
    assign act_adj_o    = q.act.adj;
    assign act_peak_o   = q.peak;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(q.act) && $stable(q.peak)));  // R9

endmodule

// File: rtl/ssc_ramp_seq.sv
module ssc_ramp_seq
    import ssc_pkg::*;
#(
    parameter int PRM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [PRM_W-1:0] half_i,
    input  logic [PRM_W-1:0] adj_i,
    output logic             tick_o,
    output ramp_dir_e        dir_o,
    output logic             period_end_o
);

    typedef struct packed {
        logic [PRM_W-1:0] adj_cnt;
        logic [PRM_W-1:0] step_cnt;
        ramp_dir_e        dir;
    } seq_t;

    seq_t q, d;
    logic adj_hit;
    logic half_hit;

    always_comb begin
        d            = q;
        adj_hit      = (q.adj_cnt == adj_i);
        half_hit     = (q.step_cnt == half_i);
        tick_o       = en_i && adj_hit;
        period_end_o = tick_o && half_hit && (q.dir == RAMP_RISE);

        if (load_i) begin
            d = '0;
        end else if (en_i) begin
            if (adj_hit) begin
                d.adj_cnt = '0;
                if (half_hit) begin
                    d.step_cnt = '0;
                    d.dir      = (q.dir == RAMP_FALL) ? RAMP_RISE : RAMP_FALL;
                end else begin
                    d.step_cnt = q.step_cnt + PRM_W'(1);
                end
            end else begin
                d.adj_cnt = q.adj_cnt + PRM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dir_o = q.dir;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (q.adj_cnt == '0 && q.step_cnt == '0 && q.dir == RAMP_FALL));  // R3
    AST_ADJ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> q.adj_cnt <= adj_i);  // R7
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> q.step_cnt <= half_i);  // R8

endmodule

// File: rtl/ssc_dev_acc.sv
module ssc_dev_acc
    import ssc_pkg::*;
#(
    parameter int WORD_W = 26,
    parameter int PRM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              tick_i,
    input  ramp_dir_e         dir_i,
    input  logic [PRM_W-1:0]  step_i,
    output logic [WORD_W-1:0] dev_o
);

    localparam logic [WORD_W:0] DEV_CAP = {1'b0, {WORD_W{1'b1}}};

    typedef struct packed {
        logic [WORD_W-1:0] dev;
    } acc_t;

    acc_t            q, d;
    logic [WORD_W:0] grown;

    always_comb begin
        d     = q;
        grown = {1'b0, q.dev} + (WORD_W + 1)'(step_i);
        if (load_i) begin
            d.dev = '0;
        end else if (tick_i) begin
            if (dir_i == RAMP_FALL)
                d.dev = (grown > DEV_CAP) ? {WORD_W{1'b1}} : grown[WORD_W-1:0];
            else
                d.dev = (q.dev < WORD_W'(step_i)) ? '0 : q.dev - WORD_W'(step_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dev_o = q.dev;

    AST_FALL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && dir_i == RAMP_FALL && !load_i) |=> dev_o >= $past(dev_o));  // R10
    AST_RISE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && dir_i == RAMP_RISE && !load_i) |=> dev_o <= $past(dev_o));  // R10

endmodule

// File: rtl/ssc_word_map.sv
module ssc_word_map #(
    parameter int WORD_W = 26
) (
    input  logic              en_i,
    input  logic              center_i,
    input  logic [WORD_W-1:0] nom_i,
    input  logic [WORD_W-1:0] peak_i,
    input  logic [WORD_W-1:0] dev_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int SUM_W = WORD_W + 3;
    localparam logic signed [SUM_W-1:0] WORD_CAP = SUM_W'({WORD_W{1'b1}});

    logic signed [SUM_W-1:0] base;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        base = $signed({3'b000, nom_i});
        if (center_i) base = base + $signed({3'b000, peak_i >> 1});
        sum = base - $signed({3'b000, dev_i});

        if (!en_i)               word_o = nom_i;
        else if (sum < 0)        word_o = '0;
        else if (sum > WORD_CAP) word_o = {WORD_W{1'b1}};
        else                     word_o = sum[WORD_W-1:0];
    end

endmodule

// File: rtl/ssc_fracdiv_mod.sv
module ssc_fracdiv_mod
    import ssc_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 18,
    parameter int PRM_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr_en,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [7:0]              cfg_wdata,
    output logic [INT_W+FRAC_W-1:0] div_word
);

    localparam int WORD_W = INT_W + FRAC_W;

    logic              act_en;
    logic              act_center;
    logic [WORD_W-1:0] act_nom;
    logic [PRM_W-1:0]  act_half;
    logic [PRM_W-1:0]  act_step;
    logic [PRM_W-1:0]  act_adj;
    logic [WORD_W-1:0] act_peak;
    logic              tick;
    ramp_dir_e         dir;
    logic              period_end;
    logic              load;
    logic [WORD_W-1:0] dev;

    // Settings move from shadow to active while idle, or as a triangle closes.
    assign load = !act_en || period_end;

    ssc_cfg_bank #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W),
        .PRM_W (PRM_W),
        .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .load_i      (load),
        .act_en_o    (act_en),
        .act_center_o(act_center),
        .act_nom_o   (act_nom),
        .act_half_o  (act_half),
        .act_step_o  (act_step),
        .act_adj_o   (act_adj),
        .act_peak_o  (act_peak)
    );

    ssc_ramp_seq #(
        .PRM_W(PRM_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (act_en),
        .load_i      (load),
        .half_i      (act_half),
        .adj_i       (act_adj),
        .tick_o      (tick),
        .dir_o       (dir),
        .period_end_o(period_end)
    );

    ssc_dev_acc #(
        .WORD_W(WORD_W),
        .PRM_W (PRM_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .tick_i(tick),
        .dir_i (dir),
        .step_i(act_step),
        .dev_o (dev)
    );

    ssc_word_map #(
        .WORD_W(WORD_W)
    ) u_map (
        .en_i    (act_en),
        .center_i(act_center),
        .nom_i   (act_nom),
        .peak_i  (act_peak),
        .dev_i   (dev),
        .word_o  (div_word)
    );

    AST_IDLE_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> div_word == act_nom);  // R3
    AST_DOWN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !act_center) |-> div_word <= act_nom);  // R5

endmodule

// File: tb/sim_ssc_fracdiv_mod.sv
module sim_ssc_fracdiv_mod;

    localparam longint WMAX = (64'd1 << 26) - 1;

    logic        clk;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [25:0] div_word;

    int checks = 0;
    int errors = 0;

    ssc_fracdiv_mod u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr_en(cfg_wr_en),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .div_word (div_word)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Closed-form word at cycle n (0 = first cycle after the loading edge).
    function automatic logic [25:0] exp_word(input longint nom, input longint s,
                                             input longint h, input longint a,
                                             input bit ctr, input longint n);
        longint t;
        longint peak;
        longint dev;
        longint w;
        t    = n / (a + 1);
        peak = s * (h + 1);
        if (peak > WMAX) peak = WMAX;
        if (t <= h + 1) begin
            dev = t * s;
            if (dev > WMAX) dev = WMAX;
        end else begin
            dev = peak - (t - (h + 1)) * s;
            if (dev < 0) dev = 0;
        end
        w = nom - dev;
        if (ctr) w = w + peak / 2;
        if (w < 0) w = 0;
        if (w > WMAX) w = WMAX;
        return 26'(w);
    endfunction

    task automatic chk(input logic [25:0] exp, input string tag);
        checks++;
        if (div_word !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, div_word, exp);
        end
    endtask

    task automatic wr(input logic [3:0] addr, input logic [7:0] data);
        cfg_wr_en = 1'b1;
        cfg_addr  = addr;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_nom(input logic [25:0] nom);
        wr(4'd0, nom[25:18]);
        wr(4'd1, nom[7:0]);
        wr(4'd2, nom[15:8]);
        wr(4'd3, {6'b0, nom[17:16]});
    endtask

    task automatic set_ramp(input logic [15:0] h, input logic [15:0] s, input logic [15:0] a);
        wr(4'd5, h[7:0]);
        wr(4'd6, h[15:8]);
        wr(4'd7, s[7:0]);
        wr(4'd8, s[15:8]);
        wr(4'd9, a[7:0]);
        wr(4'd10, a[15:8]);
    endtask

    task automatic run_span(input logic [25:0] nom, input int s, input int h, input int a,
                            input bit ctr, input int n0, input int n1, input string tag);
        for (int n = n0; n < n1; n++) begin
            chk(exp_word(nom, s, h, a, ctr, n), tag);
            @(negedge clk);
        end
    endtask

    // Program while idle, run exactly one triangle, then confirm return to idle.
    task automatic one_triangle(input logic [25:0] nom, input int s, input int h,
                                input int a, input bit ctr, input string tag);
        int p;
        p = 2 * (h + 1) * (a + 1);
        set_nom(nom);
        set_ramp(16'(h), 16'(s), 16'(a));
        wr(4'd4, {6'b0, 1'b1, ctr});
        wr(4'd4, 8'h00);
        run_span(nom, s, h, a, ctr, 0, p, tag);
        chk(nom, "R8 triangle closes at nominal after 2(H+1)(A+1) cycles");
        @(negedge clk);
        chk(nom, "R3 idle after pending disable holds nominal");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cfg_wr_en = 1'b0;
        cfg_addr  = '0;
        cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(26'h0, "R1 word after reset");
        @(negedge clk);
        chk(26'h0, "R1 word stays zero while idle");

        // R2: byte assembly, high fraction field keeps only two bits
        wr(4'd0, 8'hA5);
        wr(4'd1, 8'h3C);
        wr(4'd2, 8'h96);
        wr(4'd3, 8'hFF);
        @(negedge clk);
        chk({8'hA5, 2'b11, 8'h96, 8'h3C}, "R2 nominal assembly");
        wr(4'd0, 8'h12);
        chk({8'hA5, 2'b11, 8'h96, 8'h3C}, "R3 one edge after write not yet visible");
        @(negedge clk);
        chk({8'h12, 2'b11, 8'h96, 8'h3C}, "R3 write visible two edges later");

        // R11: unused addresses must not alias any setting
        set_nom(26'h2345678);
        set_ramp(16'd2, 16'd40, 16'd1);
        for (int ad = 11; ad < 16; ad++) wr(4'(ad), 8'hFF);
        @(negedge clk);
        chk(26'h2345678, "R11 nominal untouched by unused addresses");
        wr(4'd4, 8'h02);
        wr(4'd4, 8'h00);
        run_span(26'h2345678, 40, 2, 1, 1'b0, 0, 12, "R11 ramp settings untouched");
        chk(26'h2345678, "R11 back to nominal");

        // R4: control bit mapping
        set_nom(26'h1800000);
        set_ramp(16'd1, 16'd50, 16'd0);
        wr(4'd4, 8'h01);
        for (int i = 0; i < 4; i++) begin
            chk(26'h1800000, "R4 center bit alone keeps modulation off");
            @(negedge clk);
        end
        wr(4'd4, 8'hFC);
        for (int i = 0; i < 4; i++) begin
            chk(26'h1800000, "R4 upper control bits ignored");
            @(negedge clk);
        end
        wr(4'd4, 8'h03);
        wr(4'd4, 8'h00);
        run_span(26'h1800000, 50, 1, 0, 1'b1, 0, 4, "R4 bits 1 and 0 give center spread");
        chk(26'h1800000, "R4 disabled after triangle");

        // R5 R6 R7 R8: sweep of small configurations in both modes
        for (int h = 0; h < 4; h++)
            for (int a = 0; a < 3; a++)
                for (int c = 0; c < 2; c++)
                    for (int si = 0; si < 2; si++) begin
                        logic [25:0] nom;
                        int s;
                        s   = (si == 0) ? 3 : 16'h1234;
                        nom = {8'(8'h40 + h * 3 + a), 18'h2A5A5};
                        one_triangle(nom, s, h, a, c[0],
                                     (c != 0) ? "R6 center sweep, R7 step interval"
                                              : "R5 down sweep, R7 step interval");
                    end

        // R9: mid-sweep write lands at next triangle start; disable likewise
        set_nom(26'h2000000);
        set_ramp(16'd2, 16'd100, 16'd1);
        wr(4'd4, 8'h02);
        @(negedge clk);
        run_span(26'h2000000, 100, 2, 1, 1'b0, 0, 3, "R9 first triangle");
        wr(4'd7, 8'd200);
        run_span(26'h2000000, 100, 2, 1, 1'b0, 4, 12, "R9 old step held until triangle ends");
        run_span(26'h2000000, 200, 2, 1, 1'b0, 0, 2, "R9 new step from next triangle");
        wr(4'd4, 8'h00);
        run_span(26'h2000000, 200, 2, 1, 1'b0, 3, 12, "R9 disable waits for triangle end");
        chk(26'h2000000, "R9 disabled at triangle end");

        // R10: saturation of the deviation and clamping of the word
        one_triangle(26'(WMAX), 16'hFFFF, 1024, 0, 1'b0, "R10 deviation saturates");
        one_triangle(26'd100, 16'hFFFF, 3, 1, 1'b0, "R10 word clamps at zero");
        one_triangle(26'(WMAX), 1000, 3, 0, 1'b1, "R10 word clamps at maximum");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule